// File: doc/BRIEF.md
# Trimmable Nanosecond Time-of-Day Counter

This block keeps a free-running nanosecond time-of-day count for precision time protocol hardware. On every reference clock cycle in which it is enabled, the count moves forward by a programmable step. Software trims the clock rate by choosing a second, alternate step that replaces the normal one once every N enabled cycles. The count can be made to fold back at a programmable period, which keeps the remainder, so that the time base is, for example, 31 bits wide. Each fold raises a one-cycle pulse for compare logic downstream.

Software reaches the block through a small register port. A write to the time register loads the count directly. Because the count changes on every cycle, software reads a snapshot instead of the live count. Setting the snapshot request bit starts a short sequence in a state machine: IDLE moves to HOLD_OFF on a request, HOLD_OFF lasts `CAP_DELAY` cycles and then moves to LATCH, and LATCH copies the live count into the snapshot and returns to IDLE. The request bit reads back as 1 from the request until the copy has been made. The live count also leaves the block on a port so that neighbouring timestamp logic can use it.

The register addresses are: 0 control, 1 time, 2 step, 3 trim spacing, 4 fold period. Control has these bits: 0 run, 4 fold enable, 5 stored only, 7 compare-across-fold enable, 11 snapshot request or busy. The step register holds the normal step in bits 6:0 and the alternate step in bits 14:8.

Top module: `tod_counter`

## Requirements
- R1: After reset, tod_now is 0 and wrap_pulse is 0. Control, step and trim spacing read back as 0, and the fold period (address 4) reads back as 0x8000_0000.
- R2: On each cycle in which control bit 0 is set, tod_now grows by the normal step, which is step register bits 6:0.
- R3: When the trim spacing (address 3) holds N > 0, the alternate step (step bits 14:8) replaces the normal step on every Nth run cycle. N = 1 uses it on every cycle and N = 0 never uses it.
- R4: A write to the trim spacing register restarts the spacing, so the next alternate step comes N run cycles after the write.
- R5: With control bit 4 set and a nonzero fold period P, a step that would bring the count to P or above leaves count + step − P instead. wrap_pulse is high for exactly the cycle after that step.
- R6: With control bit 4 clear, the count never folds at P. It rolls over at its full width and wrap_pulse stays low.
- R7: With control bit 0 clear, tod_now holds its value and wrap_pulse stays low.
- R8: A write to the time register (address 1) sets tod_now to the written value in the next cycle, whether or not the counter runs.
- R9: Writing control with bit 11 set starts a snapshot. Bit 11 reads 1 until the copy is made CAP_DELAY + 1 cycles after the write, then reads 0. Address 1 then reads the count as it stood at the copy.
- R10: Control bit 7 drives wrap_cmp_en and reads back from control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tod_now | output | 32 | Live nanosecond count |
| wrap_pulse | output | 1 | One-cycle pulse after a fold |
| wrap_cmp_en | output | 1 | Compare-across-fold enable for downstream logic |

## Verification
The assertions check rules that hold on every cycle. A stopped counter stays unchanged and produces no pulse. A direct load lands in the next cycle. Every fold leaves a count below the period in force. A snapshot request raises the busy flag at once, and with folding off no pulse appears. Only the bench's scenarios can show the actual arithmetic: how steps add up, where the alternate step falls and how a spacing write restarts it, the exact remainder at a fold and at an exact hit of the period, full-width rollover, and the snapshot timing with its copied value.

// File: rtl/tod_pkg.sv
package tod_pkg;
    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_TIME   = 3'd1,
        A_STEP   = 3'd2,
        A_TRIM   = 3'd3,
        A_PERIOD = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        CAP_IDLE     = 2'd0,
        CAP_HOLD_OFF = 2'd1,
        CAP_LATCH    = 2'd2
    } cap_state_e;

    localparam int CTRL_RUN   = 0;
    localparam int CTRL_FOLD  = 4;
    localparam int CTRL_AUX   = 5;
    localparam int CTRL_XFOLD = 7;
    localparam int CTRL_SNAP  = 11;
    localparam int ALT_LSB    = 8;
endpackage

// File: rtl/tod_trim.sv
module tod_trim #(
    parameter int STEP_W = 7,
    parameter int TRIM_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              restart,
    input  logic [TRIM_W-1:0] spacing,
    input  logic [STEP_W-1:0] step_norm,
    input  logic [STEP_W-1:0] step_alt,
    output logic [STEP_W-1:0] step_now
);
    logic [TRIM_W-1:0] cyc_q;
    logic              active;
    logic              hit;

    assign active = (spacing != '0);
    assign hit    = active && (cyc_q >= spacing - TRIM_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (restart) begin
            cyc_q <= '0;
        end else if (adv && active) begin
            if (hit) cyc_q <= '0;
            else     cyc_q <= cyc_q + TRIM_W'(1);
        end
    end

    always_comb begin
        step_now = hit ? step_alt : step_norm;
    end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int CNT_W  = 32,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              fold_en,
    input  logic [CNT_W-1:0]  period,
    input  logic [STEP_W-1:0] step,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  count,
    output logic              fold_pulse
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] folded;
    logic             do_fold;

    always_comb begin
        sum     = {1'b0, count} + SUM_W'(step);
        folded  = sum - {1'b0, period};
        do_fold = fold_en && (period != '0) && (sum >= {1'b0, period});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            fold_pulse <= 1'b0;
        end else if (load) begin
            count      <= load_val;
            fold_pulse <= 1'b0;
        end else if (adv) begin
            if (do_fold) begin
                count      <= folded[CNT_W-1:0];
                fold_pulse <= 1'b1;
            end else begin
                count      <= sum[CNT_W-1:0];
                fold_pulse <= 1'b0;
            end
        end else begin
            fold_pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/tod_capture.sv
module tod_capture
    import tod_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int CAP_DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] live,
    output logic             busy,
    output logic [CNT_W-1:0] snap
);
    localparam int DLY_W = $clog2(CAP_DELAY + 2);

    cap_state_e       state_q, state_d;
    logic [DLY_W-1:0] dly_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:     if (req) state_d = (CAP_DELAY == 0) ? CAP_LATCH : CAP_HOLD_OFF;
            CAP_HOLD_OFF: if (dly_q <= DLY_W'(1)) state_d = CAP_LATCH;
            CAP_LATCH:    state_d = CAP_IDLE;
            default:      state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CAP_IDLE) dly_q <= DLY_W'(CAP_DELAY);
            else if (dly_q != '0)    dly_q <= dly_q - DLY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (state_q == CAP_LATCH) begin
            snap <= live;
        end
    end

    assign busy = (state_q != CAP_IDLE);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int STEP_W     = 7,
    parameter int TRIM_W     = 31,
    parameter int CAP_DELAY  = 2,
    parameter logic [31:0] DEF_PERIOD = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  tod_now,
    output logic              wrap_pulse,
    output logic              wrap_cmp_en
);
    logic              run_q, fold_q, aux_q, xfold_q;
    logic [STEP_W-1:0] step_norm_q, step_alt_q, step_now;
    logic [TRIM_W-1:0] trim_q;
    logic [CNT_W-1:0]  period_q;
    logic              ctrl_wr, time_wr, trim_wr, cap_req, cap_busy;
    logic [CNT_W-1:0]  snap;
    logic [CNT_W-1:0]  load_val;

    always_comb begin
        ctrl_wr  = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
        time_wr  = wr_en && (reg_addr_e'(wr_addr) == A_TIME);
        trim_wr  = wr_en && (reg_addr_e'(wr_addr) == A_TRIM);
        cap_req  = ctrl_wr && wr_data[CTRL_SNAP];
        load_val = wr_data[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            fold_q      <= 1'b0;
            aux_q       <= 1'b0;
            xfold_q     <= 1'b0;
            step_norm_q <= '0;
            step_alt_q  <= '0;
            trim_q      <= '0;
            period_q    <= CNT_W'(DEF_PERIOD);
        end else if (wr_en) begin
            unique case (reg_addr_e'(wr_addr))
                A_CTRL: begin
                    run_q   <= wr_data[CTRL_RUN];
                    fold_q  <= wr_data[CTRL_FOLD];
                    aux_q   <= wr_data[CTRL_AUX];
                    xfold_q <= wr_data[CTRL_XFOLD];
                end
                A_STEP: begin
                    step_norm_q <= wr_data[STEP_W-1:0];
                    step_alt_q  <= wr_data[ALT_LSB +: STEP_W];
                end
                A_TRIM:   trim_q   <= wr_data[TRIM_W-1:0];
                A_PERIOD: period_q <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    tod_trim #(.STEP_W(STEP_W), .TRIM_W(TRIM_W)) u_trim (
        .clk(clk), .rst_n(rst_n), .adv(run_q), .restart(trim_wr),
        .spacing(trim_q), .step_norm(step_norm_q), .step_alt(step_alt_q),
        .step_now(step_now)
    );

    tod_accum #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .adv(run_q), .fold_en(fold_q),
        .period(period_q), .step(step_now), .load(time_wr),
        .load_val(load_val), .count(tod_now), .fold_pulse(wrap_pulse)
    );

    tod_capture #(.CNT_W(CNT_W), .CAP_DELAY(CAP_DELAY)) u_cap (
        .clk(clk), .rst_n(rst_n), .req(cap_req), .live(tod_now),
        .busy(cap_busy), .snap(snap)
    );

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_CTRL: begin
                rd_data[CTRL_RUN]   = run_q;
                rd_data[CTRL_FOLD]  = fold_q;
                rd_data[CTRL_AUX]   = aux_q;
                rd_data[CTRL_XFOLD] = xfold_q;
                rd_data[CTRL_SNAP]  = cap_busy;
            end
            A_TIME: rd_data[CNT_W-1:0] = snap;
            A_STEP: begin
                rd_data[STEP_W-1:0]        = step_norm_q;
                rd_data[ALT_LSB +: STEP_W] = step_alt_q;
            end
            A_TRIM:   rd_data[TRIM_W-1:0] = trim_q;
            A_PERIOD: rd_data[CNT_W-1:0]  = period_q;
            default:  rd_data = '0;
        endcase
    end

    assign wrap_cmp_en = xfold_q;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             fold_en,
    input logic             load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] now,
    input logic             pulse,
    input logic [CNT_W-1:0] period,
    input logic             cap_req,
    input logic             cap_busy
);
    p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(now));

    p_no_pulse_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pulse);

    p_fold_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fold_en && !load) |=> (pulse |-> (now < $past(period))));

    p_load_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (now == $past(load_val)));

    p_snap_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_req && !cap_busy) |=> cap_busy);

    p_no_fold_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fold_en |=> !pulse);
endmodule

bind tod_counter tod_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .fold_en(fold_q),
    .load(time_wr), .load_val(load_val), .now(tod_now), .pulse(wrap_pulse),
    .period(period_q), .cap_req(cap_req), .cap_busy(cap_busy)
);

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] tod_now;
    logic        wrap_pulse;
    logic        wrap_cmp_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    int          src_q[$];
    string       tag_q[$];
    event        ev_chk;

    localparam int SRC_NOW = 0, SRC_PULSE = 1, SRC_XF = 2, SRC_RD = 8;

    always #5 clk = ~clk;

    tod_counter u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tod_now(tod_now), .wrap_pulse(wrap_pulse), .wrap_cmp_en(wrap_cmp_en)
    );

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            @(ev_chk);
            while (exp_q.size() > 0) begin
                int          s;
                logic [31:0] e;
                logic [31:0] a;
                string       t;
                s = src_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (s >= SRC_RD) rd_addr = 3'(s - SRC_RD);
                #1;
                case (s)
                    SRC_NOW:   a = tod_now;
                    SRC_PULSE: a = {31'd0, wrap_pulse};
                    SRC_XF:    a = {31'd0, wrap_cmp_en};
                    default:   a = rd_data;
                endcase
                n_vec++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", t, a, e);
                end
            end
        end
    end

    task automatic expect_v(input int src, input logic [31:0] e, input string tag);
        src_q.push_back(src);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ->ev_chk;
    endtask

    // one write, taking effect on the next rising edge; returns at the following falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_v(SRC_NOW, 32'd0, "R1 count");
        expect_v(SRC_PULSE, 32'd0, "R1 pulse");
        expect_v(SRC_RD + 0, 32'd0, "R1 ctrl");
        expect_v(SRC_RD + 2, 32'd0, "R1 step");
        expect_v(SRC_RD + 3, 32'd0, "R1 trim");
        expect_v(SRC_RD + 4, 32'h8000_0000, "R1 period");
        idle(1);

        // R2 / R3 with spacing 0: alternate step never used
        wr(3'd2, 32'h0908);
        wr(3'd1, 32'd100);
        wr(3'd0, 32'd1);
        expect_v(SRC_NOW, 32'd100, "R8 load before run");
        idle(6);
        expect_v(SRC_NOW, 32'd148, "R2 six normal steps");

        // R3 spacing 4
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd4);
        wr(3'd0, 32'd1);
        idle(8);
        expect_v(SRC_NOW, 32'd66, "R3 spacing 4 over 8 cycles");

        // R3 spacing 1
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd1);
        wr(3'd0, 32'd1);
        idle(5);
        expect_v(SRC_NOW, 32'd45, "R3 spacing 1 every cycle");

        // R4 restart on spacing write
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'd4);
        wr(3'd0, 32'd1);
        idle(2);
        expect_v(SRC_NOW, 32'd16, "R4 before rewrite");
        wr(3'd3, 32'd4);
        expect_v(SRC_NOW, 32'd24, "R4 write cycle");
        idle(3);
        expect_v(SRC_NOW, 32'd48, "R4 restarted spacing");

        // R5 fold with remainder
        wr(3'd0, 32'd0);
        wr(3'd2, 32'h0808);
        wr(3'd3, 32'd0);
        wr(3'd4, 32'd100);
        wr(3'd1, 32'd90);
        wr(3'h0, 32'h11);
        idle(1);
        expect_v(SRC_NOW, 32'd98, "R5 below period");
        expect_v(SRC_PULSE, 32'd0, "R5 no pulse yet");
        idle(1);
        expect_v(SRC_NOW, 32'd6, "R5 folded remainder");
        expect_v(SRC_PULSE, 32'd1, "R5 pulse");
        idle(1);
        expect_v(SRC_NOW, 32'd14, "R5 after fold");
        expect_v(SRC_PULSE, 32'd0, "R5 pulse one cycle");
        // exact hit of the period
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd92);
        wr(3'd0, 32'h11);
        idle(1);
        expect_v(SRC_NOW, 32'd0, "R5 exact period");
        expect_v(SRC_PULSE, 32'd1, "R5 exact pulse");

        // R7 hold when stopped
        wr(3'd0, 32'h10);
        wr(3'd1, 32'd50);
        idle(5);
        expect_v(SRC_NOW, 32'd50, "R7 held");
        expect_v(SRC_PULSE, 32'd0, "R7 no pulse");

        // R6 no fold when fold disabled
        wr(3'd1, 32'd90);
        wr(3'd0, 32'd1);
        idle(2);
        expect_v(SRC_NOW, 32'd106, "R6 passes period");
        expect_v(SRC_PULSE, 32'd0, "R6 no pulse");
        wr(3'd1, 32'hFFFF_FFFC);
        idle(1);
        expect_v(SRC_NOW, 32'd4, "R6 full-width rollover");
        expect_v(SRC_PULSE, 32'd0, "R6 rollover no pulse");

        // R8 load wins over advance
        wr(3'd1, 32'd500);
        expect_v(SRC_NOW, 32'd500, "R8 load while running");
        idle(1);
        expect_v(SRC_NOW, 32'd508, "R8 resumes");

        // R10 compare-across-fold
        wr(3'd0, 32'h80);
        expect_v(SRC_XF, 32'd1, "R10 port");
        expect_v(SRC_RD + 0, 32'h80, "R10 readback");

        // R9 snapshot (counter stopped)
        wr(3'd1, 32'd12345);
        wr(3'd0, 32'h800);
        expect_v(SRC_RD + 0, 32'h800, "R9 busy after request");
        idle(2);
        expect_v(SRC_RD + 0, 32'h800, "R9 still busy");
        idle(1);
        expect_v(SRC_RD + 0, 32'h0, "R9 busy cleared");
        expect_v(SRC_RD + 1, 32'd12345, "R9 snapshot value");
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule